// File: doc/BRIEF.md
# Local escalation aggregation unit

This block gathers every error strobe of a small cryptographic coprocessor core and turns them into one local escalation signal, a set of sticky error bits and a fatal/non-fatal verdict. The sticky bits keep a record of every error until reset.

Hardware errors raised deep inside the core are retimed through one flop before they count, which keeps them off the critical path. Those errors are the PRNG lockup, the predecode mismatch, the data-memory read ECC error, the fetch address mismatch and the register integrity errors. The global escalation input, the software errors, the start/stop errors and errors that are already registered at their source act in the same cycle.

The escalation signal blocks the instruction-executing qualifier. That qualifier in turn gates register commits and the data-memory load request. The fatal verdict tells the wipe sequencer whether the core must lock up once secure wipe is done, or may return to idle.

Top module: `local_esc_agg`

## Requirements
- R1: A pulse on `prngZeroErr`, `predecMismatchErr`, `dmemEccErr`, `fetchAddrErr` or `baseRfIntgErr` does not raise `localEsc` in its own cycle. It raises `localEsc` in the following cycle only.
- R2: A pulse on `aluModIntgErr` or `macAccIntgErr` raises `localEsc` in the following cycle only, through the non-controller integrity flop. That flop also takes `baseRfIntgErr`.
- R3: `globalEscIn` raises `localEsc` in the same cycle, with no flop on the way.
- R4: `startStopErr`, `ctrlFatalErr`, `spuriousWeErr` and `imemEccErr` raise `localEsc` in the same cycle.
- R5: `swErr` raises `localEsc` in the same cycle. After the next clock edge it sets error bit 0.
- R6: When `swErr` and `swErrsFatal` are both high, error bit 1 is set together with bit 0 after the next edge.
- R7: A `dmemEccErr` is dropped if, in that cycle, `localEsc` is high or any error bit is already set. A dropped error causes neither escalation nor error bit 4.
- R8: While `localEsc` is high, `insnExecuting`, `commitEn` and `loadReqOut` are low. Otherwise `insnExecuting` equals `insnValid`, `commitEn` equals `commitReq` and `insnExecuting`, and `loadReqOut` equals `loadReq` and `insnExecuting`.
- R9: Error bits are sticky. Bit 0 is the software error and bit 1 the fatal software error. Bits 2 to 7 are the retimed sources: PRNG, predecode, data-memory ECC, fetch address, base register file, and non-controller integrity. Each of these is set one edge after its flop is set. Bits 8 to 12 are set one edge after their source: global, start/stop, controller fatal, spurious write enable, and instruction-memory ECC.
- R10: `fatalClass` is high exactly when any error bit other than bit 0 is set.
- R11: Reset clears all retiming flops and error bits, so after reset `localEsc`, `errBits` and `fatalClass` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| prngZeroErr | input | 1 | Local PRNG stuck at all zero (retimed) |
| predecMismatchErr | input | 1 | Predecode check mismatch (retimed) |
| dmemEccErr | input | 1 | Data-memory read ECC error (retimed, maskable) |
| fetchAddrErr | input | 1 | Fetched address differs from the requested address (retimed) |
| baseRfIntgErr | input | 1 | Base register file integrity error (retimed) |
| aluModIntgErr | input | 1 | ALU modulus integrity error (retimed) |
| macAccIntgErr | input | 1 | MAC accumulator integrity error (retimed) |
| globalEscIn | input | 1 | System-wide escalation request |
| startStopErr | input | 1 | Start/stop FSM error |
| ctrlFatalErr | input | 1 | Controller fatal error sent toward start/stop |
| spuriousWeErr | input | 1 | Spurious register-file write enable, already registered |
| imemEccErr | input | 1 | Instruction-memory ECC error, already registered |
| swErr | input | 1 | Software error strobe |
| swErrsFatal | input | 1 | Control bit: software errors count as fatal |
| insnValid | input | 1 | An instruction would execute this cycle |
| commitReq | input | 1 | Register commit request |
| loadReq | input | 1 | Data-memory load request |
| localEsc | output | 1 | Local escalation |
| insnExecuting | output | 1 | Gated execute qualifier |
| commitEn | output | 1 | Gated register commit |
| loadReqOut | output | 1 | Gated data-memory load request |
| errBits | output | 13 | Sticky error bits |
| fatalClass | output | 1 | Fatal (1) or non-fatal (0) error verdict |

## Verification
A bad retiming flop shows up at the ports in one of two ways. If the flop is dropped, escalation comes one cycle early. If it is stuck, escalation appears in a cycle with no error input. Either way, `localEsc` and the gated commit and load outputs differ from the reference in the very cycle after the pulse. A corrupted sticky bit shows up on `errBits`, and on `fatalClass`, one edge after its source acts. A wrong masking decision shows up as a spurious bit 4 two edges after a late data-memory error.

// File: rtl/esc_agg_pkg.sv
package esc_agg_pkg;
  localparam int NUM_RET = 6;
  localparam int ERR_W   = 13;

  // retimed source slots
  localparam int RET_PRNG   = 0;
  localparam int RET_PREDEC = 1;
  localparam int RET_DMEM   = 2;
  localparam int RET_FETCH  = 3;
  localparam int RET_BASERF = 4;
  localparam int RET_NCINTG = 5;

  // error bit positions
  localparam int EB_SW      = 0;
  localparam int EB_SWFATAL = 1;
  localparam int EB_RETBASE = 2;
  localparam int EB_GLOBAL  = EB_RETBASE + NUM_RET;
  localparam int EB_STSTOP  = EB_GLOBAL + 1;
  localparam int EB_CTRLFAT = EB_GLOBAL + 2;
  localparam int EB_SPURWE  = EB_GLOBAL + 3;
  localparam int EB_IMEM    = EB_GLOBAL + 4;

  typedef struct packed {
    logic [NUM_RET-1:0] retD;
    logic [ERR_W-1:0]   setBits;
  } escStrobes_t;
endpackage

// File: rtl/esc_agg_datapath.sv
module esc_agg_datapath
  import esc_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  escStrobes_t        strobes,
  output logic [NUM_RET-1:0] retQ,
  output logic [ERR_W-1:0]   errBitsQ
);
  for (genvar i = 0; i < NUM_RET; i++) begin : g_ret
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) retQ[i] <= 1'b0;
      else       retQ[i] <= strobes.retD[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errBitsQ <= '0;
    else       errBitsQ <= errBitsQ | strobes.setBits;
  end
endmodule

// File: rtl/esc_agg_control.sv
module esc_agg_control
  import esc_agg_pkg::*;
(
  input  logic               prngZeroErr,
  input  logic               predecMismatchErr,
  input  logic               dmemEccErr,
  input  logic               fetchAddrErr,
  input  logic               baseRfIntgErr,
  input  logic               aluModIntgErr,
  input  logic               macAccIntgErr,
  input  logic               globalEscIn,
  input  logic               startStopErr,
  input  logic               ctrlFatalErr,
  input  logic               spuriousWeErr,
  input  logic               imemEccErr,
  input  logic               swErr,
  input  logic               swErrsFatal,
  input  logic               insnValid,
  input  logic               commitReq,
  input  logic               loadReq,
  input  logic [NUM_RET-1:0] retQ,
  input  logic [ERR_W-1:0]   errBitsQ,
  output escStrobes_t        strobes,
  output logic               localEsc,
  output logic               insnExecuting,
  output logic               commitEn,
  output logic               loadReqOut,
  output logic               fatalClass
);
  logic combEsc;
  logic escBusy;
  logic dmemKept;

  // sources that must act in their own cycle
  assign combEsc  = globalEscIn | startStopErr | ctrlFatalErr |
                    spuriousWeErr | imemEccErr | swErr;
  assign localEsc = combEsc | (|retQ);

  // late memory error is dropped once escalation is under way
  assign escBusy  = localEsc | (|errBitsQ);
  assign dmemKept = dmemEccErr & ~escBusy;

  always_comb begin
    strobes = '0;
    strobes.retD[RET_PRNG]   = prngZeroErr;
    strobes.retD[RET_PREDEC] = predecMismatchErr;
    strobes.retD[RET_DMEM]   = dmemKept;
    strobes.retD[RET_FETCH]  = fetchAddrErr;
    strobes.retD[RET_BASERF] = baseRfIntgErr;
    strobes.retD[RET_NCINTG] = aluModIntgErr | macAccIntgErr | baseRfIntgErr;

    strobes.setBits[EB_SW]      = swErr;
    strobes.setBits[EB_SWFATAL] = swErr & swErrsFatal;
    for (int i = 0; i < NUM_RET; i++) begin
      strobes.setBits[EB_RETBASE+i] = retQ[i];
    end
    strobes.setBits[EB_GLOBAL]  = globalEscIn;
    strobes.setBits[EB_STSTOP]  = startStopErr;
    strobes.setBits[EB_CTRLFAT] = ctrlFatalErr;
    strobes.setBits[EB_SPURWE]  = spuriousWeErr;
    strobes.setBits[EB_IMEM]    = imemEccErr;
  end

  assign insnExecuting = insnValid & ~localEsc;
  assign commitEn      = commitReq & insnExecuting;
  assign loadReqOut    = loadReq & insnExecuting;

  assign fatalClass = |errBitsQ[ERR_W-1:EB_SWFATAL];
endmodule

// File: rtl/local_esc_agg.sv
module local_esc_agg
  import esc_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             prngZeroErr,
  input  logic             predecMismatchErr,
  input  logic             dmemEccErr,
  input  logic             fetchAddrErr,
  input  logic             baseRfIntgErr,
  input  logic             aluModIntgErr,
  input  logic             macAccIntgErr,
  input  logic             globalEscIn,
  input  logic             startStopErr,
  input  logic             ctrlFatalErr,
  input  logic             spuriousWeErr,
  input  logic             imemEccErr,
  input  logic             swErr,
  input  logic             swErrsFatal,
  input  logic             insnValid,
  input  logic             commitReq,
  input  logic             loadReq,
  output logic             localEsc,
  output logic             insnExecuting,
  output logic             commitEn,
  output logic             loadReqOut,
  output logic [ERR_W-1:0] errBits,
  output logic             fatalClass
);
  escStrobes_t        strobes;
  logic [NUM_RET-1:0] retQ;

  esc_agg_control u_ctrl (
    .prngZeroErr(prngZeroErr), .predecMismatchErr(predecMismatchErr),
    .dmemEccErr(dmemEccErr), .fetchAddrErr(fetchAddrErr),
    .baseRfIntgErr(baseRfIntgErr), .aluModIntgErr(aluModIntgErr),
    .macAccIntgErr(macAccIntgErr), .globalEscIn(globalEscIn),
    .startStopErr(startStopErr), .ctrlFatalErr(ctrlFatalErr),
    .spuriousWeErr(spuriousWeErr), .imemEccErr(imemEccErr),
    .swErr(swErr), .swErrsFatal(swErrsFatal),
    .insnValid(insnValid), .commitReq(commitReq), .loadReq(loadReq),
    .retQ(retQ), .errBitsQ(errBits), .strobes(strobes),
    .localEsc(localEsc), .insnExecuting(insnExecuting),
    .commitEn(commitEn), .loadReqOut(loadReqOut), .fatalClass(fatalClass)
  );

  esc_agg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .retQ(retQ), .errBitsQ(errBits)
  );
endmodule

// File: rtl/local_esc_agg_chk.sv
module local_esc_agg_chk
  import esc_agg_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             prngZeroErr,
  input logic             aluModIntgErr,
  input logic             macAccIntgErr,
  input logic             globalEscIn,
  input logic             startStopErr,
  input logic             ctrlFatalErr,
  input logic             spuriousWeErr,
  input logic             imemEccErr,
  input logic             swErr,
  input logic             swErrsFatal,
  input logic             localEsc,
  input logic             insnExecuting,
  input logic             commitEn,
  input logic             loadReqOut,
  input logic [ERR_W-1:0] errBits
);
  AST_PRNG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    prngZeroErr |=> localEsc); // R1
  AST_NCINTG_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (aluModIntgErr || macAccIntgErr) |=> localEsc); // R2
  AST_GLOBAL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    globalEscIn |-> localEsc); // R3
  AST_COMB_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (startStopErr || ctrlFatalErr || spuriousWeErr || imemEccErr) |-> localEsc); // R4
  AST_SW_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    swErr |-> localEsc); // R5
  AST_SW_FATAL_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (swErr && swErrsFatal) |=> (errBits[EB_SW] && errBits[EB_SWFATAL])); // R6
  AST_EXEC_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    localEsc |-> (!insnExecuting && !commitEn && !loadReqOut)); // R8
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((errBits & $past(errBits)) == $past(errBits))); // R9
endmodule

bind local_esc_agg local_esc_agg_chk u_chk (
  .clk(clk), .rstN(rstN), .prngZeroErr(prngZeroErr),
  .aluModIntgErr(aluModIntgErr), .macAccIntgErr(macAccIntgErr),
  .globalEscIn(globalEscIn), .startStopErr(startStopErr),
  .ctrlFatalErr(ctrlFatalErr), .spuriousWeErr(spuriousWeErr),
  .imemEccErr(imemEccErr), .swErr(swErr), .swErrsFatal(swErrsFatal),
  .localEsc(localEsc), .insnExecuting(insnExecuting),
  .commitEn(commitEn), .loadReqOut(loadReqOut), .errBits(errBits)
);

// File: tb/sim_local_esc_agg.sv
module sim_local_esc_agg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [16:0] stim = '0;

  logic localEsc, insnExecuting, commitEn, loadReqOut, fatalClass;
  logic [12:0] errBits;

  // reference state
  logic [5:0]  mRet = '0;
  logic [12:0] mBits = '0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  local_esc_agg u0 (
    .clk(clk), .rstN(rstN),
    .prngZeroErr(stim[0]), .predecMismatchErr(stim[1]), .dmemEccErr(stim[2]),
    .fetchAddrErr(stim[3]), .baseRfIntgErr(stim[4]), .aluModIntgErr(stim[5]),
    .macAccIntgErr(stim[6]), .globalEscIn(stim[7]), .startStopErr(stim[8]),
    .ctrlFatalErr(stim[9]), .spuriousWeErr(stim[10]), .imemEccErr(stim[11]),
    .swErr(stim[12]), .swErrsFatal(stim[13]), .insnValid(stim[14]),
    .commitReq(stim[15]), .loadReq(stim[16]),
    .localEsc(localEsc), .insnExecuting(insnExecuting), .commitEn(commitEn),
    .loadReqOut(loadReqOut), .errBits(errBits), .fatalClass(fatalClass)
  );

  task automatic cmp1(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // compare every output against the reference, then advance the reference
  task automatic step(logic [16:0] v, string tag);
    logic esc, exe, busy;
    logic [5:0] nRet;
    @(negedge clk);
    stim = v;
    #2;
    esc  = (|mRet) | v[7] | v[8] | v[9] | v[10] | v[11] | v[12];
    exe  = v[14] & ~esc;
    busy = esc | (|mBits);
    cmp1(tag, "localEsc", localEsc, esc);
    cmp1({tag, " R8"}, "insnExecuting", insnExecuting, exe);
    cmp1({tag, " R8"}, "commitEn", commitEn, v[15] & exe);
    cmp1({tag, " R8"}, "loadReqOut", loadReqOut, v[16] & exe);
    vectors++;
    if (errBits !== mBits) begin
      miscompares++;
      $display("FAIL %s R9 errBits actual=%h expected=%h", tag, errBits, mBits);
    end
    cmp1({tag, " R10"}, "fatalClass", fatalClass, |mBits[12:1]);
    nRet = {v[5] | v[6] | v[4], v[4], v[3], v[2] & ~busy, v[1], v[0]};
    mBits = mBits | {v[11], v[10], v[9], v[8], v[7], mRet, v[12] & v[13], v[12]};
    mRet = nRet;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    stim = '0;
    mRet = '0;
    mBits = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
    cmp1("R11", "localEsc after reset", localEsc, 1'b0);
    cmp1("R11", "fatalClass after reset", fatalClass, 1'b0);
    cmp1("R11", "errBits zero after reset", |errBits, 1'b0);
  endtask

  localparam logic [16:0] EXEC = 17'h1C000; // insnValid, commitReq, loadReq

  initial begin
    doReset();
    step(EXEC, "R8 idle");
    // R1: each retimed source, one pulse, escalation one cycle later
    for (int s = 0; s < 5; s++) begin
      doReset();
      step(EXEC | (17'h1 << s), "R1 pulse");
      step(EXEC, "R1 delayed");
      step(EXEC, "R1 after");
    end
    // R2: ALU and MAC integrity via the non-controller flop
    for (int s = 5; s < 7; s++) begin
      doReset();
      step(EXEC | (17'h1 << s), "R2 pulse");
      step(EXEC, "R2 delayed");
      step(EXEC, "R2 after");
    end
    // R3: global escalation, same cycle
    doReset();
    step(EXEC | 17'h00080, "R3 global");
    step(EXEC, "R3 after");
    // R4: remaining combinational sources
    for (int s = 8; s < 12; s++) begin
      doReset();
      step(EXEC | (17'h1 << s), "R4 comb");
      step(EXEC, "R4 after");
      step(EXEC, "R4 bit");
    end
    // R5: non-fatal software error, R10 stays low
    doReset();
    step(EXEC | 17'h01000, "R5 sw");
    step(EXEC, "R5 bit");
    step(EXEC, "R5 R10 nonfatal");
    // R6: fatal software error sets both bits
    doReset();
    step(EXEC | 17'h03000, "R6 swfatal");
    step(EXEC, "R6 bits");
    // R7: data-memory error masked while escalation active
    doReset();
    step(EXEC | 17'h00084, "R7 masked by global");
    step(EXEC, "R7 no late esc");
    step(EXEC, "R7 bit4 clear");
    step(EXEC | 17'h00004, "R7 masked by sticky");
    step(EXEC, "R7 still clear");
    // R7: masked by a retimed escalation in flight
    doReset();
    step(EXEC | 17'h00001, "R7 prng");
    step(EXEC | 17'h00004, "R7 masked by prng flop");
    step(EXEC, "R7 check");
    step(EXEC, "R7 check2");
    // R9: accumulate many bits
    doReset();
    step(EXEC | 17'h0000A, "R9 mix");
    step(EXEC | 17'h00400, "R9 mix2");
    repeat (3) step(EXEC, "R9 hold");
    // random mix against the reference
    for (int n = 0; n < 4000; n++) begin
      logic [16:0] v;
      if (n % 30 == 0) doReset();
      v = '0;
      for (int b = 0; b < 14; b++) v[b] = ($urandom_range(0, 19) == 0);
      v[13] = $urandom_range(0, 1);
      v[16:14] = 3'($urandom);
      step(v, "R1 R9 random");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired R11 actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule